// File: doc/BRIEF.md
# Fused Booth Multiply-Accumulate with Three-Vector Redundant Sum

This block multiplies two signed 16-bit operands every cycle and adds the product into a 40-bit running sum. It does not form the product first and then add it. The radix-4 Booth rows of the product and the three stored vectors of the previous sum are added together in one reduction step.

The reduction splits the 40 columns into four ranges. Each range is added by its own carry-propagate adder, and no carry passes from one range into the next inside the feedback loop. Each range writes its low bits into a sum vector. The carries out of the lower three ranges go into two sparse carry vectors, so the running total is kept as three vectors whose sum is the true value, modulo 2^40.

A separate resolver adds the three vectors into an ordinary binary result, which costs one more cycle. A `PIPE` parameter adds a register between the Booth stage and the reduction, trading one cycle of latency for a shorter path.

The control inputs work as follows:
- `in_clr` starts a new sum.
- `in_vld` supplies a product.
- Raising both together loads the product as the first term of a new sum.

Top module: `fused_booth_mac`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `res` is 0 and `res_vld` is 0. The running sum starts at zero, so a first valid operation with `in_clr` low reports exactly its own product.
- R2: A cycle with `in_vld`=1 and `in_clr`=1 replaces the running sum with the signed product of `mcand` and `mplier`, sign-extended to 40 bits. This holds for every multiplier bit pattern, including the most negative operand values.
- R3: A cycle with `in_vld`=1 and `in_clr`=0 adds the signed product to the running sum. Back-to-back cycles each add one product, with no gaps needed.
- R4: The running sum is a 40-bit two's-complement value that wraps modulo 2^40. For example, adding (-32768)*(-32768)=2^30 1024 times returns the sum to 0.
- R5: A cycle with `in_clr`=1 and `in_vld`=0 sets the running sum to zero. That cycle is reported with `res`=0 and `res_vld`=1.
- R6: A cycle with both `in_vld` and `in_clr` low leaves the running sum unchanged. It produces no `res_vld` pulse, and `res` keeps its previous value.
- R7: Each cycle with `in_vld` or `in_clr` high produces exactly one `res_vld` pulse. The pulse appears after the (2+PIPE)-th rising clock edge, counting the edge that samples the inputs. In that cycle `res` holds the sum including that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Adds the product of this cycle's operands |
| in_clr | input | 1 | Discards the running sum before this cycle's operation |
| mcand | input | OP_W | Signed multiplicand |
| mplier | input | OP_W | Signed multiplier (Booth-recoded) |
| res | output | ACC_W | Binary running sum, two's complement |
| res_vld | output | 1 | `res` reflects a newly completed operation |

## Verification
The hardest state to reach is a sum whose redundant vectors carry high values out of the lower three column ranges while the total sits beside the 2^39 boundary. A wrong carry slot or a wrong Booth correction only shows up there. The stimulus gets there by accumulating the most negative times most negative product more than a thousand times in a row, and by accumulating a large negative product until the sum wraps. Every result is compared against a 40-bit reference that the bench works out arithmetically. A default instance and an instance with `PIPE`=0 receive the same stream, with randomly placed clear-only and idle cycles between, so both latencies and every mix of control inputs are covered.

// File: rtl/fbmac_pkg.sv
package fbmac_pkg;

  // Control decoded from one overlapping multiplier triplet
  typedef struct packed {
    logic neg;  // row is inverted, +1 added at its low column
    logic dbl;  // magnitude is twice the multiplicand
    logic nz;   // row is non-zero
  } booth_sel_t;

  function automatic booth_sel_t booth_decode(input logic [2:0] trip);
    booth_sel_t s;
    s.neg = trip[2] & ~(trip[1] & trip[0]);
    s.dbl = (trip == 3'b011) || (trip == 3'b100);
    s.nz  = (trip != 3'b000) && (trip != 3'b111);
    return s;
  endfunction

  // Column boundary idx (0..4) of the four reduction clusters; the middle
  // ranges are narrower because their columns hold the most live bits.
  function automatic int cluster_edge(input int idx, input int op_w, input int acc_w);
    case (idx)
      0:       return 0;
      1:       return (3 * op_w) / 4;
      2:       return (5 * op_w) / 4;
      3:       return (7 * op_w) / 4;
      default: return acc_w;
    endcase
  endfunction

endpackage

// File: rtl/fbmac_booth_rows.sv
module fbmac_booth_rows #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  localparam int NPP  = OP_W / 2
) (
  input  logic [OP_W-1:0]             mcand,
  input  logic [OP_W-1:0]             mplier,
  output logic [NPP-1:0][ACC_W-1:0]   rows,
  output logic [ACC_W-1:0]            corr
);
  import fbmac_pkg::*;

  logic [OP_W:0]      mp_ext;   // multiplier with an implicit zero below bit 0
  logic [ACC_W-1:0]   m_one;
  logic [ACC_W-1:0]   m_two;
  logic [NPP-1:0]     row_neg;

  assign mp_ext = {mplier, 1'b0};
  assign m_one  = {{(ACC_W-OP_W){mcand[OP_W-1]}}, mcand};
  assign m_two  = {m_one[ACC_W-2:0], 1'b0};

  for (genvar g = 0; g < NPP; g++) begin : g_row
    booth_sel_t       sel;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] signed_row;

    assign sel = booth_decode(mp_ext[2*g+2 -: 3]);

    always_comb begin
      if (!sel.nz)     mag = '0;
      else if (sel.dbl) mag = m_two;
      else             mag = m_one;
      signed_row = sel.neg ? ~mag : mag;
    end

    assign rows[g]    = signed_row << (2 * g);
    assign row_neg[g] = sel.neg;
  end

  always_comb begin
    corr = '0;
    for (int i = 0; i < NPP; i++) begin
      corr[2*i] = row_neg[i];
    end
  end

endmodule

// File: rtl/fbmac_cluster.sv
module fbmac_cluster #(
  parameter int ACC_W = 40,
  parameter int NOPS  = 12,
  parameter int LO    = 0,
  parameter int HI    = 12,
  parameter int OUT_W = 16,
  localparam int W    = HI - LO
) (
  input  logic [NOPS-1:0][ACC_W-1:0] ops,
  output logic [OUT_W-1:0]           total
);
  // Carry-propagate sum of one column range of every operand; OUT_W may
  // exceed W to keep the carry-out, or equal W to drop it (top range).
  always_comb begin
    total = '0;
    for (int k = 0; k < NOPS; k++) begin
      total = total + OUT_W'(ops[k][HI-1:LO]);
    end
  end

endmodule

// File: rtl/fbmac_resolve.sv
module fbmac_resolve #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] vec_a,
  input  logic [ACC_W-1:0] vec_b,
  input  logic [ACC_W-1:0] vec_c,
  output logic [ACC_W-1:0] res,
  output logic             res_vld
);
  logic             pend;
  logic [ACC_W-1:0] sum3;

  always_comb begin
    sum3 = vec_a + vec_b + vec_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= pend;
      if (pend) res <= sum3;
    end
  end

endmodule

// File: rtl/fused_booth_mac.sv
module fused_booth_mac #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int PIPE  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_clr,
  input  logic [OP_W-1:0]  mcand,
  input  logic [OP_W-1:0]  mplier,
  output logic [ACC_W-1:0] res,
  output logic             res_vld
);
  import fbmac_pkg::*;

  localparam int NPP  = OP_W / 2;
  localparam int NOPS = NPP + 4;          // rows, correction, three state vectors
  localparam int CW   = $clog2(NOPS);     // carry-out width of one cluster
  localparam int NCL  = 4;
  localparam int LAT  = 2 + PIPE;
  localparam int C1   = cluster_edge(1, OP_W, ACC_W);
  localparam int C2   = cluster_edge(2, OP_W, ACC_W);
  localparam int C3   = cluster_edge(3, OP_W, ACC_W);

  // ---------------- Booth stage ----------------
  logic [NPP-1:0][ACC_W-1:0] pp_c;
  logic [ACC_W-1:0]          corr_c;

  fbmac_booth_rows #(.OP_W(OP_W), .ACC_W(ACC_W)) u_rows (
    .mcand (mcand),
    .mplier(mplier),
    .rows  (pp_c),
    .corr  (corr_c)
  );

  logic [NPP-1:0][ACC_W-1:0] stg_pp;
  logic [ACC_W-1:0]          stg_corr;
  logic                      stg_vld;
  logic                      stg_clr;

  if (PIPE != 0) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_pp   <= '0;
        stg_corr <= '0;
      end else if (in_vld) begin
        stg_pp   <= pp_c;
        stg_corr <= corr_c;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_vld <= 1'b0;
        stg_clr <= 1'b0;
      end else begin
        stg_vld <= in_vld;
        stg_clr <= in_clr;
      end
    end
  end else begin : g_direct
    assign stg_pp   = pp_c;
    assign stg_corr = corr_c;
    assign stg_vld  = in_vld;
    assign stg_clr  = in_clr;
  end

  // ---------------- Fused reduction ----------------
  logic [ACC_W-1:0]           st_a, st_b, st_c;
  logic [ACC_W-1:0]           nxt_a, nxt_b, nxt_c;
  logic [NOPS-1:0][ACC_W-1:0] ops;
  logic                       stg_upd;
  logic [CW-1:0]              carry [NCL-1];

  assign stg_upd = stg_vld | stg_clr;

  always_comb begin
    for (int k = 0; k < NPP; k++) begin
      ops[k] = stg_vld ? stg_pp[k] : '0;
    end
    ops[NPP]   = stg_vld ? stg_corr : '0;
    ops[NPP+1] = stg_clr ? '0 : st_a;
    ops[NPP+2] = stg_clr ? '0 : st_b;
    ops[NPP+3] = stg_clr ? '0 : st_c;
  end

  for (genvar g = 0; g < NCL; g++) begin : g_cl
    localparam int LO = cluster_edge(g, OP_W, ACC_W);
    localparam int HI = cluster_edge(g + 1, OP_W, ACC_W);
    localparam int W  = HI - LO;

    if (g < NCL - 1) begin : g_keep
      logic [W+CW-1:0] tot;
      fbmac_cluster #(
        .ACC_W(ACC_W), .NOPS(NOPS), .LO(LO), .HI(HI), .OUT_W(W + CW)
      ) u_cl (
        .ops  (ops),
        .total(tot)
      );
      assign nxt_a[HI-1:LO] = tot[W-1:0];
      assign carry[g]       = tot[W+CW-1:W];
    end else begin : g_wrap
      logic [W-1:0] tot;
      fbmac_cluster #(
        .ACC_W(ACC_W), .NOPS(NOPS), .LO(LO), .HI(HI), .OUT_W(W)
      ) u_cl (
        .ops  (ops),
        .total(tot)
      );
      assign nxt_a[HI-1:LO] = tot;
    end
  end

  // Carries land at the first column of the next range; ranges 0 and 2
  // share one sparse vector, range 1 uses the other.
  always_comb begin
    nxt_b = '0;
    nxt_c = '0;
    nxt_b[C1 +: CW] = carry[0];
    nxt_b[C3 +: CW] = carry[2];
    nxt_c[C2 +: CW] = carry[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_a <= '0;
      st_b <= '0;
      st_c <= '0;
    end else if (stg_upd) begin
      st_a <= nxt_a;
      st_b <= nxt_b;
      st_c <= nxt_c;
    end
  end

  // ---------------- Redundant to binary ----------------
  fbmac_resolve #(.ACC_W(ACC_W)) u_resolve (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (stg_upd),
    .vec_a  (st_a),
    .vec_b  (st_b),
    .vec_c  (st_c),
    .res    (res),
    .res_vld(res_vld)
  );

  // ---------------- Assertions ----------------
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_clr && !stg_vld) |=> (st_a == '0 && st_b == '0 && st_c == '0)); // R5

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(stg_vld || stg_clr) |=> ($stable(st_a) && $stable(st_b) && $stable(st_c))); // R6

  AST_RES_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> $stable(res)); // R6

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(in_vld || in_clr, LAT)); // R7

  AST_CLR_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_clr && !stg_vld) |=> ##1 (res_vld && res == '0)); // R5

endmodule

// File: tb/fused_booth_mac_bench.sv
module fused_booth_mac_bench;
  localparam int OP_W  = 16;
  localparam int ACC_W = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic             in_clr = 1'b0;
  logic [OP_W-1:0]  mcand = '0;
  logic [OP_W-1:0]  mplier = '0;
  logic [ACC_W-1:0] res_p, res_d;
  logic             rv_p, rv_d;

  always #10 clk = ~clk;  // 50 MHz

  fused_booth_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) u_fused_booth_mac (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_clr(in_clr),
    .mcand(mcand), .mplier(mplier), .res(res_p), .res_vld(rv_p)
  );

  fused_booth_mac #(.OP_W(OP_W), .ACC_W(ACC_W), .PIPE(0)) u_fused_booth_mac_p0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_clr(in_clr),
    .mcand(mcand), .mplier(mplier), .res(res_d), .res_vld(rv_d)
  );

  int               total = 0;
  int               bad = 0;
  bit               done = 1'b0;
  logic [ACC_W-1:0] acc_ref = '0;
  logic [ACC_W-1:0] h_val [4];
  logic             h_v   [4];
  string            h_tag [4];
  logic [ACC_W-1:0] last_p = '0;
  logic [ACC_W-1:0] last_d = '0;
  logic [31:0]      rng = 32'h1234_5678;

  task automatic chk(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Pipelined instance: 3 edges (history slot 2); direct instance: 2 edges (slot 1).
  task automatic observe();
    chk("R7", ACC_W'(rv_p), ACC_W'(h_v[2]));
    if (h_v[2]) begin
      chk(h_tag[2], res_p, h_val[2]);
      last_p = h_val[2];
    end else begin
      chk("R6", res_p, last_p);
    end
    chk("R7", ACC_W'(rv_d), ACC_W'(h_v[1]));
    if (h_v[1]) begin
      chk(h_tag[1], res_d, h_val[1]);
      last_d = h_val[1];
    end else begin
      chk("R6", res_d, last_d);
    end
  endtask

  task automatic step(input bit v, input bit c, input logic [OP_W-1:0] a,
                      input logic [OP_W-1:0] b, input string tag);
    longint prod;
    observe();
    in_vld = v;
    in_clr = c;
    mcand  = a;
    mplier = b;
    if (c) acc_ref = '0;
    if (v) begin
      prod    = longint'($signed(a)) * longint'($signed(b));
      acc_ref = acc_ref + prod[ACC_W-1:0];
    end
    for (int k = 3; k > 0; k--) begin
      h_val[k] = h_val[k-1];
      h_v[k]   = h_v[k-1];
      h_tag[k] = h_tag[k-1];
    end
    h_val[0] = acc_ref;
    h_v[0]   = v | c;
    h_tag[0] = tag;
    @(negedge clk);
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  logic [OP_W-1:0] edge_v [16];

  initial begin
    edge_v = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001, 16'h0002,
               16'h7FFF, 16'hFFFE, 16'h5555, 16'hAAAA, 16'h3039, 16'hCFC7,
               16'h00FF, 16'hFF00, 16'h0100, 16'h4000};
    for (int k = 0; k < 4; k++) begin
      h_val[k] = '0;
      h_v[k]   = 1'b0;
      h_tag[k] = "R1";
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", res_p, '0);
    chk("R1", ACC_W'(rv_p), '0);
    chk("R1", res_d, '0);
    chk("R1", ACC_W'(rv_d), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ACC_W'(rv_p), '0);
    chk("R1", ACC_W'(rv_d), '0);

    // R1: first operation without clear reports only its product
    step(1'b1, 1'b0, 16'hFFFD, 16'h0007, "R1");

    // R2: extreme operand cross product, each a fresh sum
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        step(1'b1, 1'b1, edge_v[i], edge_v[j], "R2");
      end
    end

    // R2: every low-byte multiplier pattern, both signs, several multiplicands
    for (int b = -256; b < 256; b++) begin
      step(1'b1, 1'b1, 16'h8000, 16'(b), "R2");
      step(1'b1, 1'b1, 16'h7FFF, 16'(b), "R2");
      step(1'b1, 1'b1, 16'hB6D3, 16'(b * 131), "R2");
    end

    // R3/R5/R6: random mixed stream
    for (int n = 0; n < 3000; n++) begin
      rng = next_rng(rng);
      case (rng[3:0])
        4'd0:    step(1'b0, 1'b0, rng[31:16], rng[15:0], "R6");
        4'd1:    step(1'b0, 1'b1, rng[31:16], rng[15:0], "R5");
        4'd2:    step(1'b1, 1'b1, rng[31:16], rng[15:0], "R2");
        default: step(1'b1, 1'b0, rng[31:16], rng[15:0], "R3");
      endcase
    end

    // R4: repeated most-negative squared, wrap through 2^39 and back to 0
    step(1'b1, 1'b1, 16'h8000, 16'h8000, "R4");
    for (int n = 0; n < 1100; n++) step(1'b1, 1'b0, 16'h8000, 16'h8000, "R4");

    // R4: negative accumulation past -2^39
    step(1'b1, 1'b1, 16'h7FFF, 16'h8000, "R4");
    for (int n = 0; n < 600; n++) step(1'b1, 1'b0, 16'h7FFF, 16'h8000, "R4");

    // R5 then R6: clear only, then idle cycles
    step(1'b0, 1'b1, 16'h1111, 16'h2222, "R5");
    for (int n = 0; n < 5; n++) step(1'b0, 1'b0, 16'h7FFF, 16'h7FFF, "R6");
    step(1'b1, 1'b0, 16'h0003, 16'hFFFB, "R3");
    for (int n = 0; n < 5; n++) step(1'b0, 1'b0, 16'h0000, 16'h0000, "R6");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule